// File: doc/BRIEF.md
# MDIO Management Master with Register Access

This block runs management frames on a two-wire MDC/MDIO link to an Ethernet PHY. Software drives it through two registers on a small synchronous bus. The first is a command word. It holds the target device address, the register number, a divider code for MDC and a direction flag. The second holds 16 bits of data. Writing the command word with its go bit set launches one frame. A write frame sends the contents of the data register. A read frame returns the PHY's answer into that register.

While a frame is in flight, the go bit reads back as 1. It drops by itself on the system clock edge that ends the last MDC period. Software polls it and treats a bit that stays set too long as a fault, so the block never leaves it set once a frame has completed. The divider code stays in the command word from one frame to the next.

The MDIO pad is split into an output, an output enable and an input. During the turnaround and data phases of a read the master releases the line and samples it on MDC rising edges. Otherwise it drives the line and changes it only on MDC falling edges.

Top module: `mdio_mgmt_master`

## Requirements
- R1: While reset is applied and after it is released, MDC and the MDIO output enable are low, and both registers read as zero.
- R2: The command word sits at bus address 0. Bit 0 is the go/busy bit, bit 1 is the write flag, bits 5:2 are the divider code, bits 10:6 are the register number and bits 15:11 are the device address. Bits 31:16 read zero. The data register sits at address 1, holds bits 15:0 and reads zero above them. Each field keeps only its own bits. Writing the command word with bit 0 clear while idle stores the fields and starts nothing.
- R3: Writing the command word with bit 0 set while idle starts a frame: a write frame when bit 1 is set, a read frame otherwise. Bit 0 reads 1 from the next clock until the frame ends and then reads 0. The address, register, divider and direction fields keep their values throughout.
- R4: A write frame, bit by bit, is 32 ones, start 01, opcode 01, the 5-bit device address, the 5-bit register number, turnaround 10 and the 16 data bits, each MSB first. All of it is driven with the output enable high.
- R5: A read frame drives 32 ones, start 01, opcode 10, the device address and the register number. It then releases MDIO (output enable low) for the turnaround and the 16 data bits. It samples those data bits MSB first on MDC rising edges. When busy clears, the data register holds the sampled value.
- R6: MDC stays low when idle. During a frame its period is 2*(code+2) system clocks, where code is the divider field.
- R7: Bus writes to either register while a frame is in flight are ignored. They change no register, alter no frame and start no extra frame.
- R8: Busy stays high for exactly 128*(code+2) system clocks per frame (64 MDC periods), so it always clears.
- R9: The MDIO output only changes on a system clock edge where MDC falls. The input is sampled on edges where MDC rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe, one clock per write |
| bus_addr | input | 1 | Register select: 0 command word, 1 data register |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for the selected address, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable, high when the master drives |

## Verification
A wrong bit index or shift content inside the frame engine corrupts the serial pattern on MDIO. It shows in the 64-bit frame comparison made as the last MDC rising edge of that frame arrives. A divider counter fault shows as a wrong MDC period at the very next rising edge. A busy flag that ends early or late shows as a poll count different from 128*(code+2), and a read capture fault shows as a wrong data register value as soon as busy drops. Writes poked in the middle of a frame would show up as an unexpected frame on the wire or as changed register contents once the frame finishes.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int BUS_W  = 32;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int CODE_W = 4;
  localparam int DATA_W = 16;
  localparam int CMD_W  = PHY_W + REG_W + CODE_W + 2;

  // command word image, MSB first: device, register, divider, write, go
  typedef struct packed {
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regad;
    logic [CODE_W-1:0] div_code;
    logic              wr;
    logic              go;
  } cmd_t;

  localparam logic SEL_CMD  = 1'b0;
  localparam logic SEL_DATA = 1'b1;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_code,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);

  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;
  logic             mdc_q, mdc_d, term;

  // half period is code+2 clocks, so the terminal count is code+1
  assign half_m1 = CNT_W'(div_code) + CNT_W'(1);
  assign term    = run && !restart && (cnt_q == half_m1);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (restart || !run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_evt = term && !mdc_q;
  assign fall_evt = term && mdc_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= half_m1)) else $error("divider count beyond half period"); // R6

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_wr,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);

  localparam int FRAME_LEN = PREAMBLE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = PREAMBLE_LEN + 4 + PHY_W + REG_W;
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(TA_POS + 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  typedef enum logic {ST_IDLE, ST_SHIFT} st_t;

  st_t                  st_q, st_d;
  logic                 wr_q, wr_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d, frame_word;
  logic [DATA_W-1:0]    rd_q, rd_d;
  logic                 last_bit;

  assign frame_word = { {PREAMBLE_LEN{1'b1}},
                        2'b01,
                        (is_wr ? 2'b01 : 2'b10),
                        phy,
                        regad,
                        (is_wr ? 2'b10 : 2'b00),
                        (is_wr ? wdata : {DATA_W{1'b0}}) };

  assign last_bit = (idx_q == LAST_IDX);
  assign done     = (st_q == ST_SHIFT) && fall_evt && last_bit;

  always_comb begin
    st_d  = st_q;
    wr_d  = wr_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    rd_d  = rd_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_SHIFT;
          wr_d  = is_wr;
          idx_d = '0;
          sh_d  = frame_word;
        end
      end
      ST_SHIFT: begin
        if (rise_evt && !wr_q && (idx_q >= DATA_IDX)) begin
          rd_d = {rd_q[DATA_W-2:0], mdio_i};
        end
        if (fall_evt) begin
          if (last_bit) begin
            st_d = ST_IDLE;
          end else begin
            idx_d = idx_q + IDX_W'(1);
            sh_d  = {sh_q[FRAME_LEN-2:0], 1'b0};
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      wr_q  <= 1'b0;
      idx_q <= '0;
      sh_q  <= '0;
      rd_q  <= '0;
    end else begin
      st_q  <= st_d;
      wr_q  <= wr_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      rd_q  <= rd_d;
    end
  end

  assign busy    = (st_q == ST_SHIFT);
  assign rd_data = rd_q;
  assign mdio_o  = busy ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe = busy && (wr_q || (idx_q < TA_IDX));

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy) else $error("start seen while a frame runs"); // R7

  AST_FRAME_OPENS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mdio_oe && mdio_o)) else $error("frame did not open with driven preamble"); // R4

  AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt)) else $error("MDC rise and fall in one clock"); // R9

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_data,
  output cmd_t              cmd,
  output logic [DATA_W-1:0] wdata,
  output logic              start
);

  cmd_t              cmd_q, cmd_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              cmd_wr, dat_wr;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata[BUS_W-1:CMD_W];

  assign cmd_wr = bus_we && (bus_addr == SEL_CMD)  && !busy;
  assign dat_wr = bus_we && (bus_addr == SEL_DATA) && !busy;
  assign start  = cmd_wr && bus_wdata[0];

  always_comb begin
    cmd_d = cmd_q;
    if (cmd_wr) begin
      cmd_d    = cmd_t'(bus_wdata[CMD_W-1:0]);
      cmd_d.go = 1'b0;
    end
  end

  always_comb begin
    data_d = data_q;
    if (dat_wr) begin
      data_d = bus_wdata[DATA_W-1:0];
    end else if (done && !cmd_q.wr) begin
      data_d = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    if (bus_addr == SEL_CMD) begin
      bus_rdata = { {(BUS_W-CMD_W){1'b0}}, cmd_q.phy, cmd_q.regad,
                    cmd_q.div_code, cmd_q.wr, busy };
    end else begin
      bus_rdata = { {(BUS_W-DATA_W){1'b0}}, data_q };
    end
  end

  assign cmd   = cmd_q;
  assign wdata = data_q;

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q)) else $error("command fields moved mid-frame"); // R3

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data_q)) else $error("data register moved mid-frame"); // R7

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);

  localparam int FRAME_LEN  = PREAMBLE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int MAX_BUSY   = 2 * FRAME_LEN * ((1 << CODE_W) + 1);
  localparam int BUSY_CNT_W = $clog2(MAX_BUSY + 1);

  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  cmd_t              cmd;
  logic [DATA_W-1:0] wdata, rd_data;
  logic              start, busy, done, rise_evt, fall_evt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  mdio_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .cmd       (cmd),
    .wdata     (wdata),
    .start     (start)
  );

  mdio_clk_div #(.DIV_W(CODE_W)) i_div (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run      (busy),
    .restart  (start),
    .div_code (cmd.div_code),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_engine #(.PREAMBLE_LEN(PREAMBLE_LEN)) i_frame (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start),
    .is_wr    (bus_wdata[1]),
    .phy      (bus_wdata[15:11]),
    .regad    (bus_wdata[10:6]),
    .wdata    (wdata),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .done     (done),
    .rd_data  (rd_data),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  // frame length watch for the busy bound
  logic [BUSY_CNT_W-1:0] busy_cnt, busy_limit;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)  busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + BUSY_CNT_W'(1);
    else           busy_cnt <= '0;
  end

  assign busy_limit = BUSY_CNT_W'(2 * FRAME_LEN) *
                      (BUSY_CNT_W'(cmd.div_code) + BUSY_CNT_W'(2));

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |-> (busy_cnt < busy_limit)) else $error("busy outlived its frame"); // R8

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> !mdc) else $error("MDC toggling while idle"); // R6

  AST_MDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(mdio_o) |-> $fell(mdc)) else $error("MDIO moved off an MDC falling edge"); // R9

endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = 64;
  localparam int DATA_POS   = 48;

  typedef struct {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [3:0]  cr;
    logic [15:0] data;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic        bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        mdc;
  logic        mdio_i;
  logic        mdio_o;
  logic        mdio_oe;

  int    n_chk;
  int    n_fail;
  int    r9_bad;
  bit    rst_seen;
  time   t_fall;
  item_t sb_q[$];
  item_t cur;
  int    k;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mdc       (mdc),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [63:0] exp_bits(item_t it);
    return {32'hFFFF_FFFF, 2'b01, (it.wr ? 2'b01 : 2'b10), it.phy, it.rg,
            (it.wr ? 2'b10 : 2'b00), (it.wr ? it.data : 16'h0000)};
  endfunction

  function automatic logic [63:0] exp_oe(item_t it);
    return it.wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, {18{1'b0}}};
  endfunction

  // monitor: capture each frame on MDC rising edges and compare
  initial begin
    logic [63:0] bits;
    logic [63:0] oes;
    time         t_last;
    bit          per_bad;
    k = 0;
    bits = '0;
    oes = '0;
    t_last = 0;
    per_bad = 0;
    forever begin
      @(posedge mdc);
      #1;
      if (k == 0) begin
        per_bad = 0;
        if (sb_q.size() == 0) begin
          check(1'b0, "R7 frame with no command", 64'd1, 64'd0);
        end else begin
          cur = sb_q[0];
        end
      end else if (($time - t_last) != 2 * (cur.cr + 2) * CLK_PERIOD) begin
        per_bad = 1;
      end
      t_last = $time;
      bits[FRAME_BITS-1-k] = mdio_oe ? mdio_o : 1'b0;
      oes[FRAME_BITS-1-k]  = mdio_oe;
      k++;
      if (k == FRAME_BITS) begin
        if (cur.wr) begin
          check(bits == exp_bits(cur), "R4 write frame bits", bits, exp_bits(cur));
          check(oes == exp_oe(cur), "R4 write frame enable", oes, exp_oe(cur));
        end else begin
          check(bits == exp_bits(cur), "R5 read frame bits", bits, exp_bits(cur));
          check(oes == exp_oe(cur), "R5 read frame release", oes, exp_oe(cur));
        end
        check(!per_bad, "R6 MDC period", {63'd0, per_bad}, 64'd0);
        if (sb_q.size() != 0) void'(sb_q.pop_front());
        k = 0;
      end
    end
  end

  // PHY side: present read data after each MDC falling edge
  initial begin
    mdio_i = 1'b1;
    forever begin
      @(negedge mdc);
      #1;
      t_fall = $time - 1;
      if (k >= DATA_POS && !cur.wr) mdio_i = cur.data[15 - (k - DATA_POS)];
      else if (k == DATA_POS - 1)   mdio_i = 1'b0;
      else                          mdio_i = 1'b1;
    end
  end

  // R9: every MDIO output change lines up with an MDC falling edge
  initial begin
    t_fall = 0;
    forever begin
      @(mdio_o);
      #1;
      if (rst_seen && (t_fall != $time - 1)) r9_bad++;
    end
  end

  task automatic bus_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic run_txn(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [3:0] cr, input logic [15:0] data, input bit poke);
    item_t it;
    int    n;
    logic [31:0] exp_cmd;
    it.wr = wr; it.phy = phy; it.rg = rg; it.cr = cr; it.data = data;
    sb_q.push_back(it);
    if (wr) bus_write(1'b1, {16'h0000, data});
    bus_write(1'b0, {16'h0000, phy, rg, cr, wr, 1'b1});
    bus_addr = 1'b0;
    #1;
    check(bus_rdata[0] == 1'b1, "R3 busy after go", {63'd0, bus_rdata[0]}, 64'd1);
    if (poke) begin
      bus_write(1'b1, 32'h0000_DEAD);
      bus_write(1'b0, {16'h0000, 5'd3, 5'd4, 4'd7, 1'b1, 1'b1});
      bus_addr = 1'b0;
      #1;
    end
    n = 0;
    while (bus_rdata[0] && n < 5000) begin
      n++;
      @(negedge clk);
      #1;
    end
    if (!poke) check(n == 128 * (cr + 2), "R8 busy duration", n, 128 * (cr + 2));
    exp_cmd = {16'h0000, phy, rg, cr, wr, 1'b0};
    check(bus_rdata == exp_cmd, poke ? "R7 command kept" : "R3 fields kept",
          bus_rdata, exp_cmd);
    bus_addr = 1'b1;
    #1;
    check(bus_rdata == {16'h0000, data},
          poke ? "R7 data kept" : (wr ? "R4 data kept" : "R5 read data"),
          bus_rdata, {16'h0000, data});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; r9_bad = 0; rst_seen = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins in reset", {mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_seen = 1;
    #1;
    check(bus_rdata == 32'h0, "R1 command after reset", bus_rdata, 64'd0);
    bus_addr = 1'b1;
    #1;
    check(bus_rdata == 32'h0, "R1 data after reset", bus_rdata, 64'd0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins after reset", {mdc, mdio_oe}, 64'd0);

    // R2: field masking, no launch without go
    bus_write(1'b0, 32'hFFFF_FFFE);
    bus_addr = 1'b0;
    #1;
    check(bus_rdata == 32'h0000_FFFE, "R2 command image", bus_rdata, 32'h0000_FFFE);
    repeat (40) @(negedge clk);
    #1;
    check(mdc == 1'b0 && mdio_oe == 1'b0 && k == 0, "R6 idle MDC quiet",
          {mdc, mdio_oe}, 64'd0);
    bus_write(1'b1, 32'hABCD_1234);
    bus_addr = 1'b1;
    #1;
    check(bus_rdata == 32'h0000_1234, "R2 data image", bus_rdata, 32'h0000_1234);

    run_txn(1'b1, 5'h01, 5'h00, 4'd0,  16'hA5C3, 1'b0);
    run_txn(1'b0, 5'h1F, 5'h1E, 4'd3,  16'h8001, 1'b0);
    run_txn(1'b1, 5'h15, 5'h0A, 4'd15, 16'h0FF0, 1'b0);
    run_txn(1'b1, 5'h06, 5'h11, 4'd2,  16'h1357, 1'b1);
    run_txn(1'b0, 5'h00, 5'h00, 4'd0,  16'hFFFF, 1'b0);
    run_txn(1'b0, 5'h02, 5'h01, 4'd1,  16'h5A5A, 1'b0);

    repeat (200) @(negedge clk);
    check(sb_q.size() == 0 && k == 0, "R7 no extra frame", sb_q.size(), 64'd0);
    check(r9_bad == 0, "R9 MDIO changes on MDC fall", r9_bad, 64'd0);
    summary();
    $finish;
  end

endmodule